// File: doc/BRIEF.md
# Serial GPIO Expander Controller

This block adds general-purpose lines to a chip through two external shift-register chains, using four pins. A serial-in parallel-out chain carries the output lines. A parallel-load serial-out chain carries the input lines. One scan engine serves both chains. It shares the serial clock and a single load/shift strobe between them. The strobe is low to load and high to shift.

Every scan has three parts:

- The strobe goes low for one serial clock period, which loads the input chain in parallel.
- With the strobe high, the engine shifts `max(input count, output count)` bits, sending output data and sampling input data on each rising serial clock edge.
- A short low-then-high strobe pulse latches the output chain's storage register.

The sampled inputs become visible only when the scan ends. Scans repeat for as long as the enable is held.

Configuration is supplied as register-facing ports: the two line counts, the clock divider, the output values, and a per-input interrupt enable and sensitivity. Outputs include the committed input values, the per-line pending status and one active-high combined interrupt. Each input line can be set to level-high, level-low, rising-edge or falling-edge sensitivity. Edge events stay pending until software clears them with a write-one pulse.

Top module: `serial_io_expander`

## Requirements
- R1: After reset, `sclk_o` is 0, `strobe_o` is 1, `sdo_o` is 0, and `in_val_o`, `irq_pend_o` and `irq_o` are all 0.
- R2: With divider value N, each serial clock half-period lasts N+1 system clocks, so a full period is 2×(N+1). The divider is captured at the start of each scan.
- R3: Each scan begins with `strobe_o` low for 2×(N+1) clocks while `sclk_o` stays low. `sclk_o` never rises while `strobe_o` is low.
- R4: A scan produces exactly L = max(in count, out count) rising `sclk_o` edges. Counts above the parameter maximum are clamped to that maximum.
- R5: Output line k (k < out count) is sent at shift position L-1-k, most significant line first. Padding positions send 0. After the last bit, `strobe_o` goes low for N+1 clocks and then high, which latches the chain. `sdo_o` is 0 whenever `strobe_o` is low.
- R6: On the rising `sclk_o` edge of shift position j (j < in count), the bit on `sdi_i` is taken as input line in_count-1-j. Lines at or above the in count read 0. `in_val_o` changes only when a scan completes.
- R7: Scans repeat back to back while `scan_en_i` is high. When it drops, the running scan completes and the pins park with `strobe_o` high and `sclk_o` low.
- R8: Sensitivity code 2'b00 (level-high) makes a line pending while its committed value is 1. Code 2'b01 (level-low) makes it pending while the value is 0. Codes are taken from `irq_mode_i[2i+1:2i]`.
- R9: Code 2'b10 (rising) sets the pending flag when a completed scan changes the line from 0 to 1. Code 2'b11 (falling) sets it on a change from 1 to 0. The flag holds until `irq_clr_i[i]` is pulsed, and a set in the same cycle wins over the clear.
- R10: A line whose `irq_en_i` bit is 0 shows no pending status. `irq_o` is the OR of all pending bits.
- R11: With both counts 0, a scan has no shift phase and no `sclk_o` edges, and `in_val_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scan_en_i | input | 1 | Run scans continuously while high |
| div_i | input | DIV_W | Divider value N; serial period is 2×(N+1) clocks |
| out_cnt_i | input | clog2(MAX_OUT+1) | Number of output lines |
| in_cnt_i | input | clog2(MAX_IN+1) | Number of input lines |
| out_val_i | input | MAX_OUT | Values for the output lines |
| irq_en_i | input | MAX_IN | Per-input interrupt enable |
| irq_mode_i | input | 2×MAX_IN | Per-input sensitivity code |
| irq_clr_i | input | MAX_IN | Write-one pulse that clears edge pending flags |
| in_val_o | output | MAX_IN | Input values committed at the end of the last scan |
| irq_pend_o | output | MAX_IN | Per-input pending status |
| irq_o | output | 1 | Combined interrupt, active high |
| sclk_o | output | 1 | Serial clock to both chains |
| strobe_o | output | 1 | Load (low) / shift (high) strobe |
| sdo_o | output | 1 | Serial data to the output chain |
| sdi_i | input | 1 | Serial data from the input chain |

## Verification
The bench attaches behavioural models of both external chains to the pins. It sweeps line-count pairs in which the input count is larger, smaller, equal or zero, with distinct bit patterns. This separates the zero-padding at the front of the output stream from the dropped trailing samples on the input side, and it catches any bit reversal. Divider values 0, 1 and 3 distinguish half-period timing from full-period timing. Interrupt patterns are chosen so that the rising and falling sets differ, and a repeated identical scan shows that edges fire only on a change.

// File: rtl/sgx_pkg.sv
package sgx_pkg;
  typedef enum logic [1:0] {
    SENSE_HIGH = 2'b00,
    SENSE_LOW  = 2'b01,
    SENSE_RISE = 2'b10,
    SENSE_FALL = 2'b11
  } sense_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOAD,
    ST_SHIFT,
    ST_LATCH
  } scan_st_e;
endpackage

// File: rtl/sgx_clk_div.sv
module sgx_clk_div #(
  parameter int DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;
  logic             wrap;

  assign wrap   = (cnt_q == div_i);
  assign tick_o = run_i && wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (!run_i || wrap) cnt_q <= '0;
    else                     cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/sgx_scan.sv
module sgx_scan
  import sgx_pkg::*;
#(
  parameter int MAX_OUT = 64,
  parameter int MAX_IN  = 64,
  parameter int DIV_W   = 16,
  parameter int OCW     = $clog2(MAX_OUT + 1),
  parameter int ICW     = $clog2(MAX_IN + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic [DIV_W-1:0]   div_i,
  input  logic [OCW-1:0]     out_cnt_i,
  input  logic [ICW-1:0]     in_cnt_i,
  input  logic [MAX_OUT-1:0] out_val_i,
  input  logic               sdi_i,
  input  logic               tick_i,
  output logic               run_o,
  output logic [DIV_W-1:0]   div_q_o,
  output logic               sclk_o,
  output logic               strobe_o,
  output logic               sdo_o,
  output logic               commit_o,
  output logic [MAX_IN-1:0]  word_o
);
  localparam int MAXL = (MAX_OUT > MAX_IN) ? MAX_OUT : MAX_IN;
  localparam int LW   = $clog2(MAXL + 1);

  scan_st_e         st_q;
  logic             ph_q;
  logic [LW-1:0]    bit_q, len_q, icnt_q;
  logic [MAXL-1:0]  out_sr_q, in_sr_q;
  logic [DIV_W-1:0] div_q;
  logic             sclk_q;

  logic [LW-1:0]    oc_c, ic_c, len_c;
  logic [MAXL-1:0]  oval_ext, omask, oload, ishift;
  logic             start, scan_end;

  // clamp counts to the build maximum
  always_comb begin
    oc_c  = (int'(out_cnt_i) > MAX_OUT) ? LW'(MAX_OUT) : LW'(out_cnt_i);
    ic_c  = (int'(in_cnt_i)  > MAX_IN)  ? LW'(MAX_IN)  : LW'(in_cnt_i);
    len_c = (oc_c > ic_c) ? oc_c : ic_c;
    oval_ext = '0;
    oval_ext[MAX_OUT-1:0] = out_val_i;
    for (int k = 0; k < MAXL; k++) omask[k] = (k < int'(oc_c));
    // MSB-first alignment: line len-1 lands in the top bit
    oload = (oval_ext & omask) << (MAXL - int'(len_c));
  end

  // trailing samples past the input chain are dropped
  always_comb begin
    ishift = in_sr_q >> (len_q - icnt_q);
    for (int k = 0; k < MAX_IN; k++) word_o[k] = ishift[k] && (k < int'(icnt_q));
  end

  assign scan_end = (st_q == ST_LATCH) && tick_i && ph_q;
  assign start    = ((st_q == ST_IDLE) && en_i) || (scan_end && en_i);
  assign commit_o = scan_end;
  assign run_o    = (st_q != ST_IDLE);
  assign div_q_o  = div_q;
  assign sclk_o   = sclk_q;
  assign strobe_o = !((st_q == ST_LOAD) || ((st_q == ST_LATCH) && !ph_q));
  assign sdo_o    = (st_q == ST_SHIFT) && out_sr_q[MAXL-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      ph_q     <= 1'b0;
      bit_q    <= '0;
      len_q    <= '0;
      icnt_q   <= '0;
      div_q    <= '0;
      out_sr_q <= '0;
      in_sr_q  <= '0;
      sclk_q   <= 1'b0;
    end else if (start) begin
      st_q     <= ST_LOAD;
      ph_q     <= 1'b0;
      bit_q    <= '0;
      len_q    <= len_c;
      icnt_q   <= ic_c;
      div_q    <= div_i;
      out_sr_q <= oload;
      in_sr_q  <= '0;
      sclk_q   <= 1'b0;
    end else if (tick_i) begin
      unique case (st_q)
        ST_LOAD: begin
          ph_q <= !ph_q;
          if (ph_q) begin
            bit_q <= '0;
            st_q  <= (len_q == '0) ? ST_LATCH : ST_SHIFT;
          end
        end
        ST_SHIFT: begin
          ph_q <= !ph_q;
          if (!ph_q) begin
            sclk_q  <= 1'b1;
            in_sr_q <= {in_sr_q[MAXL-2:0], sdi_i};
          end else begin
            sclk_q   <= 1'b0;
            out_sr_q <= out_sr_q << 1;
            if (bit_q == len_q - 1'b1) st_q <= ST_LATCH;
            else                       bit_q <= bit_q + 1'b1;
          end
        end
        ST_LATCH: begin
          ph_q <= !ph_q;
          if (ph_q) st_q <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sgx_irq.sv
module sgx_irq
  import sgx_pkg::*;
#(
  parameter int N = 64
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           commit_i,
  input  logic [N-1:0]   word_i,
  input  logic [N-1:0]   en_i,
  input  logic [2*N-1:0] mode_i,
  input  logic [N-1:0]   clr_i,
  output logic [N-1:0]   val_o,
  output logic [N-1:0]   pend_o,
  output logic           irq_o
);
  logic [N-1:0] val_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       val_q <= '0;
    else if (commit_i) val_q <= word_i;
  end

  for (genvar i = 0; i < N; i++) begin : g_line
    sense_e sense;
    logic   edge_q, hit;

    assign sense = sense_e'(mode_i[2*i +: 2]);
    assign hit = commit_i && en_i[i] &&
                 (((sense == SENSE_RISE) &&  word_i[i] && !val_q[i]) ||
                  ((sense == SENSE_FALL) && !word_i[i] &&  val_q[i]));

    // set beats clear
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       edge_q <= 1'b0;
      else if (hit)      edge_q <= 1'b1;
      else if (clr_i[i]) edge_q <= 1'b0;
    end

    always_comb begin
      unique case (sense)
        SENSE_HIGH: pend_o[i] = en_i[i] &&  val_q[i];
        SENSE_LOW:  pend_o[i] = en_i[i] && !val_q[i];
        default:    pend_o[i] = en_i[i] &&  edge_q;
      endcase
    end
  end

  assign val_o = val_q;
  assign irq_o = |pend_o;
endmodule

// File: rtl/serial_io_expander.sv
module serial_io_expander #(
  parameter int MAX_OUT = 64,
  parameter int MAX_IN  = 64,
  parameter int DIV_W   = 16,
  localparam int OCW    = $clog2(MAX_OUT + 1),
  localparam int ICW    = $clog2(MAX_IN + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                scan_en_i,
  input  logic [DIV_W-1:0]    div_i,
  input  logic [OCW-1:0]      out_cnt_i,
  input  logic [ICW-1:0]      in_cnt_i,
  input  logic [MAX_OUT-1:0]  out_val_i,
  input  logic [MAX_IN-1:0]   irq_en_i,
  input  logic [2*MAX_IN-1:0] irq_mode_i,
  input  logic [MAX_IN-1:0]   irq_clr_i,
  output logic [MAX_IN-1:0]   in_val_o,
  output logic [MAX_IN-1:0]   irq_pend_o,
  output logic                irq_o,
  output logic                sclk_o,
  output logic                strobe_o,
  output logic                sdo_o,
  input  logic                sdi_i
);
  logic             run, tick, commit;
  logic [DIV_W-1:0] div_q;
  logic [MAX_IN-1:0] word;

  sgx_clk_div #(.DIV_W(DIV_W)) i_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .div_i  (div_q),
    .tick_o (tick)
  );

  sgx_scan #(
    .MAX_OUT (MAX_OUT),
    .MAX_IN  (MAX_IN),
    .DIV_W   (DIV_W),
    .OCW     (OCW),
    .ICW     (ICW)
  ) i_scan (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (scan_en_i),
    .div_i     (div_i),
    .out_cnt_i (out_cnt_i),
    .in_cnt_i  (in_cnt_i),
    .out_val_i (out_val_i),
    .sdi_i     (sdi_i),
    .tick_i    (tick),
    .run_o     (run),
    .div_q_o   (div_q),
    .sclk_o    (sclk_o),
    .strobe_o  (strobe_o),
    .sdo_o     (sdo_o),
    .commit_o  (commit),
    .word_o    (word)
  );

  sgx_irq #(.N(MAX_IN)) i_irq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .commit_i (commit),
    .word_i   (word),
    .en_i     (irq_en_i),
    .mode_i   (irq_mode_i),
    .clr_i    (irq_clr_i),
    .val_o    (in_val_o),
    .pend_o   (irq_pend_o),
    .irq_o    (irq_o)
  );
endmodule

// File: rtl/sgx_chk.sv
module sgx_chk
  import sgx_pkg::*;
#(
  parameter int MAX_OUT = 64,
  parameter int MAX_IN  = 64,
  parameter int DIV_W   = 16
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [DIV_W-1:0]    div_i,
  input logic [MAX_IN-1:0]   irq_en_i,
  input logic [2*MAX_IN-1:0] irq_mode_i,
  input logic [MAX_IN-1:0]   in_val_o,
  input logic [MAX_IN-1:0]   irq_pend_o,
  input logic                irq_o,
  input logic                sclk_o,
  input logic                strobe_o,
  input logic                sdo_o
);
  logic [DIV_W:0] hi_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     hi_cnt <= '0;
    else if (sclk_o) hi_cnt <= hi_cnt + 1'b1;
    else             hi_cnt <= '0;
  end

  assert_sclk_high_width_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sclk_o) |-> (hi_cnt == {1'b0, div_i} + 1'b1));

  assert_no_clock_in_load_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sclk_o) |-> strobe_o);

  assert_sdo_quiet_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !strobe_o |-> !sdo_o);

  assert_commit_at_end_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_val_o != $past(in_val_o)) |-> ($past(strobe_o) && !$past(sclk_o)));

  assert_masked_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_en_i == '0) |-> !irq_o);

  for (genvar i = 0; i < MAX_IN; i++) begin : g_ln
    logic [1:0] m;
    assign m = irq_mode_i[2*i +: 2];

    assert_level_low_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (irq_en_i[i] && (m == 2'(SENSE_LOW)) && !in_val_o[i]) |-> irq_pend_o[i]);

    assert_rise_sets_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($rose(in_val_o[i]) && $past(irq_en_i[i]) && ($past(m) == 2'(SENSE_RISE)) &&
       irq_en_i[i] && (m == 2'(SENSE_RISE))) |-> irq_pend_o[i]);

    assert_edge_needs_change_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($rose(irq_pend_o[i]) && m[1] && $stable(m) && $past(irq_en_i[i]))
        |-> (in_val_o[i] != $past(in_val_o[i])));
  end
endmodule

bind serial_io_expander sgx_chk #(
  .MAX_OUT (MAX_OUT),
  .MAX_IN  (MAX_IN),
  .DIV_W   (DIV_W)
) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .div_i      (div_i),
  .irq_en_i   (irq_en_i),
  .irq_mode_i (irq_mode_i),
  .in_val_o   (in_val_o),
  .irq_pend_o (irq_pend_o),
  .irq_o      (irq_o),
  .sclk_o     (sclk_o),
  .strobe_o   (strobe_o),
  .sdo_o      (sdo_o)
);

// File: tb/test_serial_io_expander.sv
`timescale 1ns/1ps
module test_serial_io_expander;
  localparam int MO = 8, MI = 8, DW = 4;

  logic          clk = 1'b0, rst_n = 1'b0;
  logic          en = 1'b0;
  logic [DW-1:0] div = '0;
  logic [3:0]    ocnt = '0, icnt = '0;
  logic [7:0]    oval = '0, ien = '0, iclr = '0;
  logic [15:0]   imode = '0;
  logic [7:0]    in_val, pend;
  logic          irq, sclk, strobe, sdo, sdi;

  int total = 0, fails = 0, cyc = 0;
  int rise_cnt = 0, bad_rise = 0, period = 0, last_rise = 0;
  int low_idx = 0, t_fall = 0;
  int low_w [4];
  int ic_model = 0;
  logic [7:0] ext_pat = '0, i_sr = '0, o_sr = '0, o_store = '0;
  bit done = 0;

  always #10 clk = !clk;

  serial_io_expander #(.MAX_OUT(MO), .MAX_IN(MI), .DIV_W(DW)) i_serial_io_expander (
    .clk_i(clk), .rst_ni(rst_n), .scan_en_i(en), .div_i(div),
    .out_cnt_i(ocnt), .in_cnt_i(icnt), .out_val_i(oval),
    .irq_en_i(ien), .irq_mode_i(imode), .irq_clr_i(iclr),
    .in_val_o(in_val), .irq_pend_o(pend), .irq_o(irq),
    .sclk_o(sclk), .strobe_o(strobe), .sdo_o(sdo), .sdi_i(sdi)
  );

  // external chain models
  assign sdi = (ic_model == 0) ? 1'b0 : i_sr[ic_model-1];
  always @(negedge strobe) i_sr <= ext_pat;
  always @(posedge sclk) begin
    if (strobe) i_sr <= i_sr << 1;
    o_sr <= {o_sr[6:0], sdo};
  end
  always @(posedge strobe) o_store <= o_sr;

  always @(posedge clk) cyc++;
  always @(posedge sclk) begin
    rise_cnt++;
    if (!strobe) bad_rise++;
    period = cyc - last_rise;
    last_rise = cyc;
  end
  always @(negedge strobe) t_fall = cyc;
  always @(posedge strobe) begin
    if (low_idx < 4) low_w[low_idx] = cyc - t_fall;
    low_idx++;
  end

  function automatic logic [7:0] msk(int n);
    return (n >= 8) ? 8'hFF : 8'((1 << n) - 1);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic one_scan(int d, int oc, int ic, logic [7:0] ov, logic [7:0] ep);
    @(negedge clk);
    div = DW'(d); ocnt = 4'(oc); icnt = 4'(ic); oval = ov;
    ext_pat = ep; ic_model = (ic > 8) ? 8 : ic;
    rise_cnt = 0; bad_rise = 0; low_idx = 0;
    en = 1'b1;
    @(negedge clk);
    en = 1'b0;
    repeat (25 * (d + 1) + 10) @(negedge clk);
  endtask

  task automatic clr_pulse(logic [7:0] m);
    @(negedge clk); iclr = m;
    @(negedge clk); iclr = '0;
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++; total++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", total, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1
    chk("R1 sclk", sclk, 0); chk("R1 strobe", strobe, 1); chk("R1 sdo", sdo, 0);
    chk("R1 in_val", in_val, 0); chk("R1 irq", {pend, irq}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2, R3, R4 timing across divider values
    foreach (low_w[k]) low_w[k] = 0;
    for (int d = 0; d < 4; d += (d == 1) ? 2 : 1) begin
      one_scan(d, 8, 6, 8'h5A, 8'h2C);
      chk("R2 period", period, 2 * (d + 1));
      chk("R3 load width", low_w[0], 2 * (d + 1));
      chk("R5 latch width", low_w[1], d + 1);
      chk("R3 no clock in load", bad_rise, 0);
      chk("R4 edge count", rise_cnt, 8);
    end

    // R5, R6, R4 sweep over count pairs
    for (int a = 0; a < 4; a++) begin
      for (int b = 0; b < 4; b++) begin
        int oc, ic;
        logic [7:0] ov, ep;
        oc = (a == 0) ? 1 : (a == 1) ? 3 : (a == 2) ? 8 : 5;
        ic = (b == 0) ? 2 : (b == 1) ? 5 : (b == 2) ? 8 : 7;
        ov = 8'h3C ^ 8'(oc * 37);
        ep = 8'hC3 ^ 8'(ic * 29);
        one_scan(a & 1, oc, ic, ov, ep);
        chk("R5 latched outputs", o_store & msk(oc), ov & msk(oc));
        chk("R6 captured inputs", in_val, ep & msk(ic));
        chk("R4 edge count sweep", rise_cnt, (oc > ic) ? oc : ic);
      end
    end

    // R4 clamp of an oversize count
    one_scan(0, 2, 12, 8'h01, 8'h96);
    chk("R4 clamp", rise_cnt, 8);
    chk("R6 clamp inputs", in_val, 8'h96);

    // R11 zero counts
    one_scan(0, 0, 0, 8'hFF, 8'hFF);
    chk("R11 no edges", rise_cnt, 0);
    chk("R11 in_val", in_val, 0);

    // R6 commit only at scan end
    one_scan(1, 4, 8, 8'h0F, 8'h11);
    @(negedge clk);
    div = 1; ext_pat = 8'hEE; ic_model = 8; en = 1'b1;
    @(negedge clk); en = 1'b0;
    repeat (20) @(negedge clk);
    chk("R6 mid-scan unchanged", in_val, 8'h11);
    repeat (40) @(negedge clk);
    chk("R6 after scan", in_val, 8'hEE);

    // R7 continuous scans and stop
    @(negedge clk);
    div = 0; ocnt = 8; icnt = 8; oval = 8'hB4; ext_pat = 8'h69; ic_model = 8;
    rise_cnt = 0; en = 1'b1;
    repeat (70) @(negedge clk);
    chk("R7 several scans", rise_cnt >= 24, 1);
    en = 1'b0;
    repeat (40) @(negedge clk);
    chk("R7 parked strobe", strobe, 1); chk("R7 parked sclk", sclk, 0);
    chk("R7 whole scans", rise_cnt % 8, 0);
    begin
      int held;
      held = rise_cnt;
      repeat (50) @(negedge clk);
      chk("R7 stays idle", rise_cnt, held);
    end
    chk("R7 outputs", o_store, 8'hB4);

    // R8 levels
    one_scan(0, 0, 8, 8'h00, 8'hA5);
    ien = 8'hFF; imode = {8{2'b00}};
    @(negedge clk);
    chk("R8 level high", pend, 8'hA5); chk("R10 irq on", irq, 1);
    imode = {8{2'b01}};
    @(negedge clk);
    chk("R8 level low", pend, 8'h5A);
    ien = 8'h00;
    @(negedge clk);
    chk("R10 masked", {pend, irq}, 0);

    // R9 edges
    ien = 8'hFF; imode = {8{2'b10}};
    clr_pulse(8'hFF);
    one_scan(0, 0, 8, 8'h00, 8'hF0);
    chk("R9 rising set", pend, 8'h50);
    clr_pulse(8'h10);
    chk("R9 partial clear", pend, 8'h40); chk("R10 irq held", irq, 1);
    clr_pulse(8'h40);
    chk("R9 cleared", {pend, irq}, 0);
    imode = {8{2'b11}};
    clr_pulse(8'hFF);
    one_scan(0, 0, 8, 8'h00, 8'h0F);
    chk("R9 falling set", pend, 8'hF0);
    clr_pulse(8'hFF);
    one_scan(0, 0, 8, 8'h00, 8'h0F);
    chk("R9 no change no edge", pend, 8'h00);
    chk("R10 irq off", irq, 0);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", total, fails);
    $finish;
  end
endmodule